// File: doc/BRIEF.md
# Configurable Logic Cluster

This block is one logic cluster of a fine-grained programmable overlay fabric. It holds eight logic elements. Each element is a six-input lookup table followed by a flip-flop that can be bypassed. Every lookup-table input has its own selector, which picks one of the cluster's 28 external inputs or one of the eight element flip-flops.

All per-cluster settings live in one serial configuration chain, which is clocked by a dedicated configuration clock. The settings are the truth tables, the input selector codes and the output mode bits. The chain has a serial output, so clusters can be daisy-chained into one long load path. A separate user clock drives the element flip-flops, so the user circuit and the loader run in independent clock domains.

Outputs are meaningful only once a complete configuration has been shifted in. While the loader has shifting enabled, the element flip-flops keep their state, so a partial reload cannot corrupt captured user state.

Top module: `olc_cluster`

## Requirements
- R1: On each rising `cfg_clk` edge with `cfg_shift` high, the chain moves one place toward `cfg_dout` and takes `cfg_din` at its input end. `cfg_dout` therefore shows the bit that entered 808 shifts earlier. With `cfg_shift` low, the chain keeps its contents.
- R2: The serial stream (first bit shifted first) has three parts, in this order:
  - the eight truth tables, element 0 first, each sent from table bit 63 down to bit 0 (positions 0 to 511);
  - the 48 selector codes, element-major with input 0 first, each 6-bit code sent MSB first (positions 512 to 799);
  - the eight mode bits, element 0 first (positions 800 to 807).
- R3: The lookup output of an element is the truth-table bit whose address has selected input i as address bit i.
- R4: Selector codes 0 to 27 pick `ext_in[code]`. Codes 28 to 35 pick the flip-flop of element code−28. Codes 36 to 63 give a constant 0.
- R5: Mode bit 0 drives `ble_out[e]` from the combinational lookup output. Mode bit 1 drives it from the element flip-flop.
- R6: On a rising `usr_clk` edge with `usr_rst` and `cfg_shift` both low, each element flip-flop captures its lookup output.
- R7: `usr_rst` high at a rising `usr_clk` edge clears every element flip-flop to 0. This takes priority over capture and hold.
- R8: While `cfg_shift` is high, the element flip-flops keep their value across `usr_clk` edges.
- R9: Feedback into the selectors is taken from the flip-flops. A chain of registered elements therefore advances one stage per `usr_clk` cycle, and a combinational element sees a feedback change in the same cycle the flip-flop updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_shift | input | 1 | Shift enable for the chain; also freezes the user flip-flops |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output for daisy-chaining |
| usr_clk | input | 1 | User logic clock for the element flip-flops |
| usr_rst | input | 1 | Synchronous reset of the element flip-flops, active high |
| ext_in | input | 28 | External cluster inputs |
| ble_out | output | 8 | Element outputs |

## Verification
The bench targets several corner cases, each tied to a specific failure.

- **Stream layout.** It loads a known stream, and reads it back through `cfg_dout` while shifting zeros in. A chain that is one bit short, reversed, or has a field misplaced would show the wrong bit at some position. It would also evaluate the wrong truth table.
- **Unused selector codes.** The out-of-range codes 36 to 63 are used on the unused LUT inputs. A selector that wrapped them onto real sources would corrupt single-input functions whenever other external bits are high.
- **Flip-flop freeze.** The bench raises `cfg_shift` with no configuration clock pulses and steps the user clock. A design that ignored the freeze would lose the captured value.
- **Registered feedback.** A two-stage registered chain is checked cycle by cycle. Feeding back the combinational output instead would collapse the stages into one cycle.
- **Mode bit.** Reloading with one element switched to registered mode shows whether the mode bit really moves the output behind a clock edge.

// File: rtl/olc_pkg.sv
package olc_pkg;

    // Default cluster geometry
    localparam int unsigned OLC_BLES    = 8;
    localparam int unsigned OLC_LUT_K   = 6;
    localparam int unsigned OLC_EXT_INS = 28;

    // Element output mode, one configuration bit per element
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

endpackage

// File: rtl/olc_cfg_chain.sv
module olc_cfg_chain #(
    parameter int unsigned LEN = 808
) (
    input  logic           cfg_clk,
    input  logic           shift,
    input  logic           din,
    output logic           dout,
    output logic [LEN-1:0] bits
);

    typedef struct packed {
        logic [LEN-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift) begin
            chain_d.bits = {chain_q.bits[LEN-2:0], din};
        end
    end

    always_ff @(posedge cfg_clk) begin
        chain_q <= chain_d;
    end

    assign bits = chain_q.bits;
    assign dout = chain_q.bits[LEN-1];

endmodule

// File: rtl/olc_input_sel.sv
module olc_input_sel #(
    parameter int unsigned N_SRC = 36,
    parameter int unsigned SEL_W = 6
) (
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] code,
    output logic             y
);

    localparam int unsigned N_CODES = 1 << SEL_W;

    // Codes at or above N_SRC select a constant zero
    logic [N_CODES-1:0] padded;

    generate
        if (N_CODES > N_SRC) begin : g_pad
            assign padded = {{(N_CODES - N_SRC){1'b0}}, src};
        end else begin : g_nopad
            assign padded = src[N_CODES-1:0];
        end
    endgenerate

    assign y = padded[code];

endmodule

// File: rtl/olc_lut.sv
module olc_lut #(
    parameter int unsigned K = 6
) (
    input  logic [(1<<K)-1:0] table_bits,
    input  logic [K-1:0]      addr,
    output logic              y
);

    assign y = table_bits[addr];

endmodule

// File: rtl/olc_ble.sv
module olc_ble #(
    parameter int unsigned K     = 6,
    parameter int unsigned N_SRC = 36,
    parameter int unsigned SEL_W = 6
) (
    input  logic [N_SRC-1:0]   src,
    input  logic [(1<<K)-1:0]  table_bits,
    input  logic [K*SEL_W-1:0] codes,
    output logic               lut_y
);

    logic [K-1:0] addr;

    generate
        for (genvar i = 0; i < K; i++) begin : g_in
            olc_input_sel #(
                .N_SRC (N_SRC),
                .SEL_W (SEL_W)
            ) u_sel (
                .src  (src),
                .code (codes[i*SEL_W +: SEL_W]),
                .y    (addr[i])
            );
        end
    endgenerate

    olc_lut #(
        .K (K)
    ) u_lut (
        .table_bits (table_bits),
        .addr       (addr),
        .y          (lut_y)
    );

endmodule

// File: rtl/olc_cluster.sv
module olc_cluster
    import olc_pkg::*;
#(
    parameter int unsigned N_BLE = OLC_BLES,
    parameter int unsigned K     = OLC_LUT_K,
    parameter int unsigned N_EXT = OLC_EXT_INS
) (
    input  logic             cfg_clk,
    input  logic             cfg_shift,
    input  logic             cfg_din,
    output logic             cfg_dout,
    input  logic             usr_clk,
    input  logic             usr_rst,
    input  logic [N_EXT-1:0] ext_in,
    output logic [N_BLE-1:0] ble_out
);

    localparam int unsigned N_SRC     = N_EXT + N_BLE;
    localparam int unsigned SEL_W     = $clog2(N_SRC);
    localparam int unsigned LUT_SZ    = 1 << K;
    localparam int unsigned SEL_BASE  = N_BLE * LUT_SZ;
    localparam int unsigned MODE_BASE = SEL_BASE + N_BLE * K * SEL_W;
    localparam int unsigned CHAIN_LEN = MODE_BASE + N_BLE;

    // Configuration chain (configuration clock domain)
    logic [CHAIN_LEN-1:0] cfg_bits;

    olc_cfg_chain #(
        .LEN (CHAIN_LEN)
    ) u_chain (
        .cfg_clk (cfg_clk),
        .shift   (cfg_shift),
        .din     (cfg_din),
        .dout    (cfg_dout),
        .bits    (cfg_bits)
    );

    // Element flip-flops (user clock domain)
    typedef struct packed {
        logic [N_BLE-1:0] ff;
    } usr_state_t;

    usr_state_t usr_d, usr_q;
    logic [N_BLE-1:0] ff_q;
    logic [N_BLE-1:0] lut_out;
    logic [N_SRC-1:0] src_bus;

    assign ff_q    = usr_q.ff;
    assign src_bus = {ff_q, ext_in};

    // Field extraction: first bit shifted sits at the chain's far end
    generate
        for (genvar e = 0; e < N_BLE; e++) begin : g_ble
            localparam int unsigned TBL_LO  = CHAIN_LEN - LUT_SZ - e * LUT_SZ;
            localparam int unsigned MODE_IX = N_BLE - 1 - e;

            logic [K*SEL_W-1:0] codes;
            out_mode_e          mode;

            for (genvar i = 0; i < K; i++) begin : g_code
                localparam int unsigned SEL_LO =
                    CHAIN_LEN - SEL_BASE - (e * K + i + 1) * SEL_W;
                assign codes[i*SEL_W +: SEL_W] = cfg_bits[SEL_LO +: SEL_W];
            end

            assign mode = out_mode_e'(cfg_bits[MODE_IX]);

            olc_ble #(
                .K     (K),
                .N_SRC (N_SRC),
                .SEL_W (SEL_W)
            ) u_ble (
                .src        (src_bus),
                .table_bits (cfg_bits[TBL_LO +: LUT_SZ]),
                .codes      (codes),
                .lut_y      (lut_out[e])
            );

            assign ble_out[e] = (mode == OUT_REG) ? ff_q[e] : lut_out[e];
        end
    endgenerate

    always_comb begin
        usr_d = usr_q;
        if (usr_rst) begin
            usr_d.ff = '0;
        end else if (!cfg_shift) begin
            usr_d.ff = lut_out;
        end
    end

    always_ff @(posedge usr_clk) begin
        usr_q <= usr_d;
    end

endmodule

// File: rtl/olc_cluster_chk.sv
module olc_cluster_chk #(
    parameter int unsigned N_BLE     = 8,
    parameter int unsigned CHAIN_LEN = 808
) (
    input logic                 usr_clk,
    input logic                 cfg_clk,
    input logic                 usr_rst,
    input logic                 cfg_shift,
    input logic                 cfg_dout,
    input logic [N_BLE-1:0]     ff_q,
    input logic [N_BLE-1:0]     lut_out,
    input logic [CHAIN_LEN-1:0] cfg_bits
);

    AST_RESET_CLEARS: assert property (@(posedge usr_clk)
        usr_rst |=> (ff_q == '0)); // R7

    AST_HOLD_IN_SHIFT: assert property (@(posedge usr_clk) disable iff (usr_rst)
        cfg_shift |=> $stable(ff_q)); // R8

    AST_CAPTURE_LUT: assert property (@(posedge usr_clk) disable iff (usr_rst)
        !cfg_shift |=> (ff_q == $past(lut_out))); // R6

    AST_DOUT_ADVANCE: assert property (@(posedge cfg_clk) disable iff (usr_rst)
        cfg_shift |=> (cfg_dout == $past(cfg_bits[CHAIN_LEN-2]))); // R1

    AST_CHAIN_IDLE: assert property (@(posedge cfg_clk) disable iff (usr_rst)
        !cfg_shift |=> $stable(cfg_bits)); // R1

endmodule

bind olc_cluster olc_cluster_chk #(
    .N_BLE     (N_BLE),
    .CHAIN_LEN (CHAIN_LEN)
) u_chk (
    .usr_clk   (usr_clk),
    .cfg_clk   (cfg_clk),
    .usr_rst   (usr_rst),
    .cfg_shift (cfg_shift),
    .cfg_dout  (cfg_dout),
    .ff_q      (ff_q),
    .lut_out   (lut_out),
    .cfg_bits  (cfg_bits)
);

// File: tb/tb_olc_cluster.sv
module tb_olc_cluster;

    localparam int NB  = 8;
    localparam int NX  = 28;
    localparam int LEN = 808;

    logic          cfg_clk = 1'b0;
    logic          cfg_shift = 1'b0;
    logic          cfg_din = 1'b0;
    logic          cfg_dout;
    logic          usr_clk = 1'b0;
    logic          usr_rst = 1'b1;
    logic [NX-1:0] ext_in = '0;
    logic [NB-1:0] ble_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic stream [LEN];

    olc_cluster dut (
        .cfg_clk   (cfg_clk),
        .cfg_shift (cfg_shift),
        .cfg_din   (cfg_din),
        .cfg_dout  (cfg_dout),
        .usr_clk   (usr_clk),
        .usr_rst   (usr_rst),
        .ext_in    (ext_in),
        .ble_out   (ble_out)
    );

    always #4 usr_clk = ~usr_clk;   // 125 MHz user clock

    // Stimulus: ext_in pattern and expected ble_out[4:0] for the combinational elements
    localparam logic [32:0] VEC [9] = '{
        {28'h0000000, 5'b10000},
        {28'h000003F, 5'b10001},
        {28'h0000040, 5'b10010},
        {28'h0001000, 5'b10100},
        {28'h0003000, 5'b10000},
        {28'h0040000, 5'b11000},
        {28'h0080000, 5'b00000},
        {28'hFFFFFFF, 5'b01011},
        {28'h000001F, 5'b10000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_lut(input int e, input logic [63:0] t);
        for (int b = 0; b < 64; b++) stream[e*64 + 63 - b] = t[b];
    endtask

    task automatic set_sel(input int e, input int i, input logic [5:0] c);
        for (int s = 0; s < 6; s++) stream[512 + (e*6 + i)*6 + 5 - s] = c[s];
    endtask

    task automatic build_cfg(input logic e0_reg);
        logic [63:0] par;
        for (int p = 0; p < LEN; p++) stream[p] = 1'b0;
        for (int e = 0; e < NB; e++)
            for (int i = 0; i < 6; i++) set_sel(e, i, 6'd63);
        for (int b = 0; b < 64; b++) par[b] = ^b[5:0];
        set_lut(0, 64'h8000_0000_0000_0000);
        set_lut(1, 64'hFFFF_FFFF_FFFF_FFFE);
        set_lut(2, par);
        set_lut(3, 64'hAAAA_AAAA_AAAA_AAAA);
        set_lut(4, 64'h5555_5555_5555_5555);
        set_lut(5, 64'hAAAA_AAAA_AAAA_AAAA);
        set_lut(6, 64'hAAAA_AAAA_AAAA_AAAA);
        set_lut(7, 64'h8888_8888_8888_8888);
        for (int i = 0; i < 6; i++) begin
            set_sel(0, i, 6'(i));
            set_sel(1, i, 6'(6 + i));
            set_sel(2, i, 6'(12 + i));
        end
        set_sel(3, 0, 6'd18);
        set_sel(4, 0, 6'd19);
        set_sel(5, 0, 6'd20);
        set_sel(6, 0, 6'd33);   // flip-flop of element 5
        set_sel(7, 0, 6'd34);   // flip-flop of element 6
        set_sel(7, 1, 6'd27);
        stream[800] = e0_reg;
        stream[805] = 1'b1;
        stream[806] = 1'b1;
    endtask

    task automatic load_stream();
        cfg_shift = 1'b1;
        for (int k = 0; k < LEN; k++) begin
            cfg_din = stream[k];
            #2 cfg_clk = 1'b1;
            #2 cfg_clk = 1'b0;
        end
        cfg_shift = 1'b0;
        #1;
    endtask

    task automatic usr_step();
        @(posedge usr_clk);
        @(negedge usr_clk);
    endtask

    initial begin
        #(8 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int bad;
        build_cfg(1'b0);
        usr_rst = 1'b1;
        repeat (3) usr_step();
        load_stream();
        usr_step();
        // R7: the flip-flops are cleared under reset even with their data input high
        ext_in = 28'h0100000;
        usr_step();
        check("R7 reset clears registered outputs", 32'(ble_out[6:5]), 32'h0);
        usr_rst = 1'b0;
        ext_in = '0;
        usr_step();
        check("R5 registered elements idle low", 32'(ble_out[7:5]), 32'h0);

        // R3 R4 R5: combinational elements across the vector table
        foreach (VEC[v]) begin
            @(negedge usr_clk);
            ext_in = VEC[v][32:5];
            #1;
            check($sformatf("R3 R4 vector %0d", v), 32'(ble_out[4:0]), 32'(VEC[v][4:0]));
        end

        // R4: unused inputs use code 63, so high bits elsewhere leave element 3 equal to ext 18
        @(negedge usr_clk);
        ext_in = 28'hFFBFFFF;
        #1;
        check("R4 out-of-range code gives zero", 32'(ble_out[3]), 32'h0);

        // R6 R9: registered pipeline 5 -> 6 -> combinational 7
        @(negedge usr_clk);
        ext_in = 28'h0;
        usr_step();
        usr_step();
        ext_in = (28'h1 << 20) | (28'h1 << 27);
        usr_step();
        check("R6 stage one captures", 32'(ble_out[6:5]), 32'h1);
        check("R9 element 7 waits for stage two", 32'(ble_out[7]), 32'h0);
        usr_step();
        check("R9 stage two one cycle later", 32'(ble_out[6:5]), 32'h3);
        check("R9 combinational use of feedback", 32'(ble_out[7]), 32'h1);

        // R8: freeze with shift enable high and no configuration clock pulses
        ext_in = 28'h8000000;
        cfg_shift = 1'b1;
        usr_step();
        usr_step();
        check("R8 flops hold during shift", 32'(ble_out[6:5]), 32'h3);
        cfg_shift = 1'b0;
        usr_step();
        check("R6 capture resumes after shift", 32'(ble_out[6:5]), 32'h2);

        // R5 R2: reload with element 0 in registered mode (mode bit at position 800)
        build_cfg(1'b1);
        load_stream();
        usr_rst = 1'b1;
        usr_step();
        usr_rst = 1'b0;
        @(negedge usr_clk);
        ext_in = 28'h000003F;
        #1;
        check("R5 registered mode hides comb value", 32'(ble_out[0]), 32'h0);
        usr_step();
        check("R5 registered mode after edge", 32'(ble_out[0]), 32'h1);

        // R1 R2: read the stream back through cfg_dout while shifting zeros in
        bad = 0;
        cfg_shift = 1'b1;
        for (int k = 0; k < LEN; k++) begin
            cfg_din = 1'b0;
            #1;
            if (cfg_dout !== stream[k]) bad++;
            #1 cfg_clk = 1'b1;
            #2 cfg_clk = 1'b0;
        end
        cfg_shift = 1'b0;
        check("R1 R2 serial readback mismatches", 32'(bad), 32'h0);

        // R1: the chain now holds zeros, so every element is combinational constant zero
        @(negedge usr_clk);
        ext_in = 28'hFFFFFFF;
        #1;
        check("R1 zero chain gives zero outputs", 32'(ble_out), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule